// File: doc/BRIEF.md
# Address-Sequence Command Unlock Detector

This block watches a synchronous, sampled view of an asynchronous SRAM-style bus. It recognises a fixed chain of six back-to-back read accesses. When the whole chain matches, it issues a one-cycle command toward a nonvolatile controller. The first five addresses of the chain form a shared prefix. The sixth address picks the command: save the array to nonvolatile storage, restore the array from it, or turn off the automatic save. Any other access that lands inside the chain breaks it, and no command is issued for that attempt.

The bus front end gives one `acc_valid` strobe per completed access, together with the write-enable level and the address of that access. Reads controlled by chip enable and reads controlled by output enable both reach the block as the same strobe, so either kind can count as a step. Only the middle slice of the address, bits 14 down to 2, is compared. While the nonvolatile controller reports `nv_busy`, the detector ignores the bus.

Top module: `nvcmd_unlock`

## Requirements
- R1: While reset is held and in the first cycle after its release, `cmd_valid` is 0 and `cmd_code` is 0 (none). Reset also clears the chain, so a lone sixth address read afterwards issues nothing.
- R2: Six reads with write-enable high (`acc_we_n`=1), to 0x4E38, 0xB1C7, 0x83E0, 0x7C1F, 0x703F and then 0x8FC0, raise `cmd_valid` with `cmd_code`=1 (save). This happens in the cycle after the sixth access is sampled.
- R3: The same prefix followed by a read of 0x4C63 issues `cmd_code`=2 (restore). Cycles without `acc_valid` between steps do not break the chain.
- R4: The same prefix followed by a read of 0x8B45 issues `cmd_code`=3 (autosave disable).
- R5: Only address bits 14..2 are compared. Changing bits 16, 15, 1 or 0 of any step does not change the result.
- R6: A write access (`acc_we_n`=0) anywhere in the chain aborts it. This includes a write to the sixth address. No command follows for that attempt, and a write never counts as a first step.
- R7: A read whose address does not match the expected step aborts the chain, and no command is issued for that attempt.
- R8: After an abort by a read, that same read is checked again as a possible first step. A breaking read of 0x4E38 followed by the other five addresses therefore issues a command.
- R9: While `nv_busy` is 1, accesses are ignored and the chain position is held. The chain then continues once `nv_busy` returns to 0.
- R10: A command lasts exactly one cycle, and `cmd_code` is 0 whenever `cmd_valid` is 0. After a command the detector is idle again, so repeating the sixth address alone issues nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | One-cycle strobe per completed bus access |
| acc_we_n | input | 1 | Write-enable level of the access (0 means write) |
| acc_addr | input | ADDR_W (17) | Address of the access |
| nv_busy | input | 1 | Nonvolatile controller busy; the bus is ignored while it is high |
| cmd_valid | output | 1 | One-cycle command pulse |
| cmd_code | output | 2 | 0 none, 1 save, 2 restore, 3 autosave disable |

## Verification
The hardest situations to reach are the ones where the chain is broken by a read that is itself a legal first step, or is frozen mid-way by `nv_busy`. In both cases the only visible trace is whether a later sixth read fires.

The scoreboard drives partial chains that end in a breaking read of 0x4E38. It also drives chains with busy-masked writes and with busy-masked terminal reads placed right at the fifth step. It then checks that the following accesses either complete the command or produce nothing.

The tests also cover chains spread over idle cycles and chains whose don't-care address bits are flipped.

// File: rtl/nvcmd_pkg.sv
// Package: shared command codes and the fixed unlock address chain.
// Assumes addresses are compared only on a configurable middle slice;
// the constants below are full 16-bit values of which that slice is used.
package nvcmd_pkg;

    typedef enum logic [1:0] {
        CMD_NONE    = 2'd0,
        CMD_SAVE    = 2'd1,
        CMD_RESTORE = 2'd2,
        CMD_AS_OFF  = 2'd3
    } cmd_t;

    localparam int PREFIX_LEN = 5;
    localparam int TERM_CNT   = 3;

    localparam logic [15:0] TERM_SAVE    = 16'h8FC0;
    localparam logic [15:0] TERM_RESTORE = 16'h4C63;
    localparam logic [15:0] TERM_AS_OFF  = 16'h8B45;

    // Address expected at prefix position idx (0-based).
    function automatic logic [15:0] prefix_addr(input int idx);
        case (idx)
            0:       return 16'h4E38;
            1:       return 16'hB1C7;
            2:       return 16'h83E0;
            3:       return 16'h7C1F;
            default: return 16'h703F;
        endcase
    endfunction

    // Terminal address for terminal slot idx: 0 save, 1 restore, 2 autosave off.
    function automatic logic [15:0] term_addr(input int idx);
        case (idx)
            0:       return TERM_SAVE;
            1:       return TERM_RESTORE;
            default: return TERM_AS_OFF;
        endcase
    endfunction

    // Command issued for terminal slot idx.
    function automatic cmd_t term_cmd(input int idx);
        case (idx)
            0:       return CMD_SAVE;
            1:       return CMD_RESTORE;
            default: return CMD_AS_OFF;
        endcase
    endfunction

endpackage

// File: rtl/nvcmd_addr_match.sv
// Module: nvcmd_addr_match
// Compares the sampled address against every prefix step and every
// terminal address in parallel, looking only at bits CMP_HI..CMP_LO.
// Assumes CMP_HI < 16 and CMP_HI < ADDR_W. Purely combinational.
module nvcmd_addr_match
    import nvcmd_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int CMP_HI = 14,
    parameter int CMP_LO = 2
) (
    input  logic [ADDR_W-1:0]     addr,
    output logic [PREFIX_LEN-1:0] pfx_hit,
    output logic [TERM_CNT-1:0]   term_hit
);
    localparam int SLICE_W = CMP_HI - CMP_LO + 1;

    logic [SLICE_W-1:0] slice;

    // Extract the compared address slice.
    always_comb slice = addr[CMP_HI:CMP_LO];

    genvar gp;
    generate
        for (gp = 0; gp < PREFIX_LEN; gp++) begin : g_pfx
            localparam logic [15:0] REF = prefix_addr(gp);
            // Hit flag for prefix position gp.
            always_comb pfx_hit[gp] = (slice == REF[CMP_HI:CMP_LO]);
        end
        for (gp = 0; gp < TERM_CNT; gp++) begin : g_term
            localparam logic [15:0] REF = term_addr(gp);
            // Hit flag for terminal slot gp.
            always_comb term_hit[gp] = (slice == REF[CMP_HI:CMP_LO]);
        end
    endgenerate

    // Terminal addresses are distinct, so at most one may hit.
    always_comb a_r10_term_exclusive: assert ($onehot0(term_hit))
        else $error("terminal matches not exclusive");

endmodule

// File: rtl/nvcmd_step_tracker.sv
// Module: nvcmd_step_tracker
// Holds the number of chain steps matched so far and decides, per
// accepted access, whether to advance, abort, restart or fire.
// Assumes 'take' is already masked by the busy input.
module nvcmd_step_tracker
    import nvcmd_pkg::*;
#(
    parameter int STEPS  = PREFIX_LEN,
    parameter int TERMS  = TERM_CNT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             is_read,
    input  logic [STEPS-1:0] pfx_hit,
    input  logic [TERMS-1:0] term_hit,
    output logic [$clog2(STEPS+1)-1:0] step,
    output logic             fire,
    output cmd_t             fire_code
);
    localparam int SW = $clog2(STEPS+1);
    localparam logic [SW-1:0] LAST = SW'(STEPS);

    logic [SW-1:0] step_nx;
    logic          cur_hit;
    logic [SW-1:0] restart;
    logic          any_term;
    cmd_t          term_code;

    // Select the prefix hit for the current position.
    always_comb begin
        cur_hit = 1'b0;
        for (int i = 0; i < STEPS; i++) begin
            if (step == SW'(i)) cur_hit = pfx_hit[i];
        end
    end

    // Decode the matching terminal slot into a command code.
    always_comb begin
        any_term  = 1'b0;
        term_code = CMD_NONE;
        for (int i = 0; i < TERMS; i++) begin
            if (term_hit[i]) begin
                any_term  = 1'b1;
                term_code = term_cmd(i);
            end
        end
    end

    // After an abort by a read, the read may itself be step one.
    always_comb restart = pfx_hit[0] ? SW'(1) : '0;

    // Next chain position and command decision.
    always_comb begin
        step_nx   = step;
        fire      = 1'b0;
        fire_code = CMD_NONE;
        if (take) begin
            if (!is_read) begin
                step_nx = '0;
            end else if (step == LAST) begin
                if (any_term) begin
                    fire      = 1'b1;
                    fire_code = term_code;
                    step_nx   = '0;
                end else begin
                    step_nx = restart;
                end
            end else if (cur_hit) begin
                step_nx = step + SW'(1);
            end else begin
                step_nx = restart;
            end
        end
    end

    // Chain position register.
    always_ff @(posedge clk) begin
        if (!rst_n) step <= '0;
        else        step <= step_nx;
    end

    a_r1_step_range: assert property (@(posedge clk) disable iff (!rst_n)
        step <= LAST) else $error("step out of range");

    a_r6_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !is_read) |=> (step == '0)) else $error("write did not abort");

    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(step)) else $error("step moved without access");

    a_r10_fire_idle: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (step == '0)) else $error("not idle after command");

endmodule

// File: rtl/nvcmd_cmd_out.sv
// Module: nvcmd_cmd_out
// Registers the command decision into a one-cycle pulse and code.
// Assumes 'fire' never holds for two consecutive cycles.
module nvcmd_cmd_out
    import nvcmd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  cmd_t fire_code,
    output logic cmd_valid,
    output cmd_t cmd_code
);
    // Output pulse and code registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_code  <= CMD_NONE;
        end else begin
            cmd_valid <= fire;
            cmd_code  <= fire ? fire_code : CMD_NONE;
        end
    end

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid) else $error("pulse longer than one cycle");

    a_r10_code_none: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |-> (cmd_code == CMD_NONE)) else $error("code without pulse");

    a_r2_code_set: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_code != CMD_NONE)) else $error("pulse without code");

endmodule

// File: rtl/nvcmd_unlock.sv
// Module: nvcmd_unlock (top)
// Detects the six-read unlock chain on a sampled SRAM-style bus and
// issues a one-cycle save / restore / autosave-disable command.
// Assumes one acc_valid strobe per completed access; accesses are
// ignored while nv_busy is high.
module nvcmd_unlock
    import nvcmd_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int CMP_HI = 14,
    parameter int CMP_LO = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_we_n,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              nv_busy,
    output logic              cmd_valid,
    output logic [1:0]        cmd_code
);
    localparam int SW = $clog2(PREFIX_LEN+1);

    logic [PREFIX_LEN-1:0] pfx_hit;
    logic [TERM_CNT-1:0]   term_hit;
    logic                  take;
    logic [SW-1:0]         step;
    logic                  fire;
    cmd_t                  fire_code;
    cmd_t                  code_q;

    // Accept an access only when the controller is not busy.
    always_comb take = acc_valid && !nv_busy;

    nvcmd_addr_match #(
        .ADDR_W (ADDR_W),
        .CMP_HI (CMP_HI),
        .CMP_LO (CMP_LO)
    ) u_match (
        .addr     (acc_addr),
        .pfx_hit  (pfx_hit),
        .term_hit (term_hit)
    );

    nvcmd_step_tracker #(
        .STEPS (PREFIX_LEN),
        .TERMS (TERM_CNT)
    ) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .is_read   (acc_we_n),
        .pfx_hit   (pfx_hit),
        .term_hit  (term_hit),
        .step      (step),
        .fire      (fire),
        .fire_code (fire_code)
    );

    nvcmd_cmd_out u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (fire),
        .fire_code (fire_code),
        .cmd_valid (cmd_valid),
        .cmd_code  (code_q)
    );

    // Present the command code as a plain vector.
    always_comb cmd_code = code_q;

    a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        nv_busy |=> $stable(step)) else $error("step moved while busy");

    a_r9_busy_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        nv_busy |=> !cmd_valid) else $error("command while busy");

    a_r6_write_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_we_n) |=> !cmd_valid) else $error("command on write");

endmodule

// File: tb/nvcmd_unlock_tb.sv
`timescale 1ns/1ps
module nvcmd_unlock_tb;
    typedef struct {
        logic [1:0] exp;
        string      tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_we_n = 1'b1;
    logic [16:0] acc_addr = '0;
    logic        nv_busy = 1'b0;
    logic        cmd_valid;
    logic [1:0]  cmd_code;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;
    item_t sb[$];

    localparam logic [16:0] PFX [5] = '{17'h04E38, 17'h0B1C7, 17'h083E0, 17'h07C1F, 17'h0703F};
    localparam logic [16:0] A_SAVE = 17'h08FC0;
    localparam logic [16:0] A_REST = 17'h04C63;
    localparam logic [16:0] A_ASOF = 17'h08B45;

    always #10 clk = ~clk;

    nvcmd_unlock u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_we_n(acc_we_n),
        .acc_addr(acc_addr), .nv_busy(nv_busy), .cmd_valid(cmd_valid), .cmd_code(cmd_code)
    );

    task automatic check(input string tag, input logic [1:0] act_c, input logic act_v,
                         input logic [1:0] exp_c);
        n_run++;
        if (act_c !== exp_c || act_v !== (exp_c != 2'd0)) begin
            n_fail++;
            $display("FAIL %s: valid=%0b code=%0d expected valid=%0b code=%0d",
                     tag, act_v, act_c, (exp_c != 2'd0), exp_c);
        end
    endtask

    // Driver: one access (or idle cycle) per call; pushes the expected result.
    task automatic drive(input bit v, input bit wr, input logic [16:0] a, input bit bz,
                         input logic [1:0] exp, input string tag);
        item_t it;
        @(negedge clk);
        acc_valid = v; acc_we_n = !wr; acc_addr = a; nv_busy = bz;
        it.exp = exp; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic rd(input logic [16:0] a, input logic [1:0] exp, input string tag);
        drive(1'b1, 1'b0, a, 1'b0, exp, tag);
    endtask

    task automatic idle(input string tag);
        drive(1'b0, 1'b0, 17'h0, 1'b0, 2'd0, tag);
    endtask

    task automatic prefix(input int n, input logic [16:0] flip, input string tag);
        for (int i = 0; i < n; i++) rd(PFX[i] ^ flip, 2'd0, tag);
    endtask

    // Monitor: pops one expected item per clock and compares after the edge.
    always @(posedge clk) begin
        #5;
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            check(it.tag, cmd_code, cmd_valid, it.exp);
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not end");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 during reset", cmd_code, cmd_valid, 2'd0);
        @(negedge clk); rst_n = 1'b1;
        idle("R1 after release");
        rd(A_SAVE, 2'd0, "R1 lone sixth after reset");
        // R2 save
        prefix(5, 17'h0, "R2 prefix");
        rd(A_SAVE, 2'd1, "R2 save");
        idle("R10 pulse one cycle");
        rd(A_SAVE, 2'd0, "R10 idle after command");
        // R3 restore with gaps
        for (int i = 0; i < 5; i++) begin rd(PFX[i], 2'd0, "R3 prefix"); idle("R3 gap"); end
        rd(A_REST, 2'd2, "R3 restore");
        // R4 autosave off
        prefix(5, 17'h0, "R4 prefix");
        rd(A_ASOF, 2'd3, "R4 autosave off");
        // R5 don't-care bits flipped
        prefix(5, 17'h18003, "R5 prefix");
        rd(A_SAVE ^ 17'h18003, 2'd1, "R5 masked save");
        prefix(5, 17'h08001, "R5 prefix b");
        rd(A_ASOF ^ 17'h10002, 2'd3, "R5 masked asoff");
        // R6 write mid-chain
        prefix(2, 17'h0, "R6 prefix");
        drive(1'b1, 1'b1, PFX[2], 1'b0, 2'd0, "R6 write step");
        rd(PFX[3], 2'd0, "R6 cont"); rd(PFX[4], 2'd0, "R6 cont");
        rd(A_SAVE, 2'd0, "R6 no cmd after write");
        // R6 write at sixth position, then read sixth
        prefix(5, 17'h0, "R6 prefix b");
        drive(1'b1, 1'b1, A_SAVE, 1'b0, 2'd0, "R6 write sixth");
        rd(A_SAVE, 2'd0, "R6 read after write");
        // R6 write of first address is not a step
        drive(1'b1, 1'b1, PFX[0], 1'b0, 2'd0, "R6 write first");
        prefix(5, 17'h0, "R6 recover"); rd(A_REST, 2'd2, "R6 recovered restore");
        // R7 mismatching read
        prefix(2, 17'h0, "R7 prefix");
        rd(17'h01234, 2'd0, "R7 stray read");
        rd(PFX[2], 2'd0, "R7 cont"); rd(PFX[3], 2'd0, "R7 cont"); rd(PFX[4], 2'd0, "R7 cont");
        rd(A_SAVE, 2'd0, "R7 no cmd");
        prefix(5, 17'h0, "R7 prefix wrong term");
        rd(17'h00004, 2'd0, "R7 wrong sixth");
        rd(A_SAVE, 2'd0, "R7 sixth after abort");
        // R8 breaking read of first address restarts
        prefix(4, 17'h0, "R8 prefix");
        rd(PFX[0], 2'd0, "R8 restart read");
        for (int i = 1; i < 5; i++) rd(PFX[i], 2'd0, "R8 cont");
        rd(A_SAVE, 2'd1, "R8 save after restart");
        prefix(5, 17'h0, "R8 prefix b");
        rd(PFX[0], 2'd0, "R8 restart at sixth");
        for (int i = 1; i < 5; i++) rd(PFX[i], 2'd0, "R8 cont b");
        rd(A_ASOF, 2'd3, "R8 asoff after restart");
        // R9 busy
        prefix(3, 17'h0, "R9 prefix");
        drive(1'b1, 1'b1, 17'h00000, 1'b1, 2'd0, "R9 busy write");
        drive(1'b1, 1'b0, 17'h01234, 1'b1, 2'd0, "R9 busy stray");
        rd(PFX[3], 2'd0, "R9 cont"); rd(PFX[4], 2'd0, "R9 cont");
        drive(1'b1, 1'b0, A_SAVE, 1'b1, 2'd0, "R9 busy sixth");
        rd(A_REST, 2'd2, "R9 restore after busy");
        idle("R10 tail");
        idle("R10 tail");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule